// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a final page table entry by reading translation tables from memory, one word at a time. A lookup arrives with a virtual address, a read/write flag, a context number and the context table base register value. The walker first fetches the context's root word, then descends through up to three table levels. It stops as soon as a word of leaf type appears, or as soon as a word it cannot follow appears.

On a leaf, the walker marks the entry as referenced. For a write lookup it also marks the entry as modified. It stores the entry back to the same memory word only when one of those bits was clear. The walker then returns the updated entry, together with the level at which the leaf was found. Any other ending returns a fault, the raw word that caused it and the level reached.

Only one walk runs at a time. The memory port is a plain valid/ready word request channel, and read data comes back on a separate valid strobe. Writes produce no response.

Top module: `pgwalk_top`

## Requirements
- R1: The first memory read of a walk is at address `((ctxBase & 0xFFFFFFF0) << 4) + ctxNum*4`, computed in 32 bits. Bits [31:28] and [3:0] of the base register therefore have no effect.
- R2: A word whose bits [1:0] equal 1 is a table pointer, and the next table starts at `(word & 0xFFFFFFF0) << 4`. The next read is at that table plus 4 times the index. The index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3. The root word counts as level 0.
- R3: A word with bits [1:0] equal 2 is a leaf at any level 0 to 3. It ends the walk with rspFault=0 and rspLevel equal to that level, and no further table read follows.
- R4: A word with bits [1:0] equal 0 or 3 ends the walk with rspFault=1, rspLevel equal to the level reached and rspEntry equal to the raw word. No write is issued.
- R5: A table pointer read at level 3 ends the walk with rspFault=1 and rspLevel=3.
- R6: On a leaf, rspEntry is the read word with bit 5 (referenced) set. Bit 6 (modified) is also set when reqWrite was 1 at acceptance. All other bits are unchanged.
- R7: One memory write is issued only when the updated leaf differs from the read word. It goes to the address the leaf was read from, and its data is the updated entry.
- R8: reqReady is high only when no walk is in progress. It falls at acceptance and stays low until the rspValid/rspReady handshake completes. Reset leaves the block idle with no request or response outstanding.
- R9: A memory request and a response, once raised, keep their valid, address, data and fields unchanged until the other side accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Walker idle, lookup accepted when reqValid is high |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Lookup is for a write access |
| ctxBase | input | 32 | Context table base register (physical address >> 4) |
| ctxNum | input | CTX_W (8) | Context number |
| rspValid | output | 1 | Lookup result valid |
| rspReady | input | 1 | Result accepted |
| rspFault | output | 1 | Walk ended in a fault |
| rspLevel | output | 2 | Level at which the walk ended (0 = root word) |
| rspEntry | output | 32 | Updated leaf entry, or the faulting word |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | Memory request is a write |
| memReqAddr | output | 32 | Memory word address (byte address) |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Read data valid |
| memRspRdata | input | 32 | Read data |

## Verification
The bench builds fresh table chains for each walk and ends them with a leaf at every level, with invalid and reserved words, and with a pointer at the last level. A walker that kept descending past a leaf, or that treated the reserved type as valid, would read extra words or return the wrong level. A walker that stopped at level 3 without faulting on a pointer would also give a wrong result. Leaves come with every combination of referenced and modified already set or clear, under read and write lookups. This catches a redundant write-back, a missing write-back, and a write-back to the wrong address. Context numbers near 255 and base register values with stray top and low bits catch a root address that drops the carry into bit 8 or fails to mask the register. Random stalls on the memory port and the response port check that requests and results hold still and that no second lookup slips in.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    ET_BAD  = 2'd0,
    ET_PTR  = 2'd1,
    ET_LEAF = 2'd2,
    ET_RSVD = 2'd3
  } entryKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadWord;
    logic descend;
    logic markFault;
  } walkCtl_t;

  // status from datapath to control
  typedef struct packed {
    entryKind_e kind;
    logic [1:0] level;
    logic       needWb;
  } walkStat_t;

  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam logic [1:0] LAST_LEVEL = 2'd3;

endpackage

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int CTX_W      = 8,
  parameter int L1_IDX_W   = 8,
  parameter int L2_IDX_W   = 6,
  parameter int L3_IDX_W   = 6,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [31:0]       reqVaddr,
  input  logic              reqWrite,
  input  logic [31:0]       ctxBase,
  input  logic [CTX_W-1:0]  ctxNum,
  input  logic [31:0]       memRdata,
  output walkStat_t         stat,
  output logic [31:0]       memAddr,
  output logic [31:0]       wbData,
  output logic [31:0]       rspEntry,
  output logic              rspFault,
  output logic [1:0]        rspLevel
);

  localparam int L3_LO = PAGE_SHIFT;
  localparam int L2_LO = L3_LO + L3_IDX_W;
  localparam int L1_LO = L2_LO + L2_IDX_W;
  localparam logic [31:0] L1_MASK = (32'd1 << L1_IDX_W) - 32'd1;
  localparam logic [31:0] L2_MASK = (32'd1 << L2_IDX_W) - 32'd1;
  localparam logic [31:0] L3_MASK = (32'd1 << L3_IDX_W) - 32'd1;
  localparam logic [31:0] PTR_MASK = 32'hFFFF_FFF0;

  logic [31:0]      vaRq;
  logic             wrRq;
  logic [CTX_W-1:0] ctxRq;
  logic [31:0]      tblBase;
  logic [1:0]       levelQ;
  logic [31:0]      wordQ;
  logic             faultQ;
  logic [31:0]      idx;
  logic [31:0]      updated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaRq    <= '0;
      wrRq    <= 1'b0;
      ctxRq   <= '0;
      tblBase <= '0;
      levelQ  <= '0;
      wordQ   <= '0;
      faultQ  <= 1'b0;
    end else begin
      if (ctl.capture) begin
        vaRq    <= reqVaddr;
        wrRq    <= reqWrite;
        ctxRq   <= ctxNum;
        tblBase <= (ctxBase & PTR_MASK) << 4;
        levelQ  <= '0;
        faultQ  <= 1'b0;
      end
      if (ctl.loadWord) wordQ <= memRdata;
      if (ctl.descend) begin
        tblBase <= (wordQ & PTR_MASK) << 4;
        levelQ  <= levelQ + 2'd1;
      end
      if (ctl.markFault) faultQ <= 1'b1;
    end
  end

  // table index for the current level
  always_comb begin
    unique case (levelQ)
      2'd0:    idx = 32'(ctxRq);
      2'd1:    idx = (vaRq >> L1_LO) & L1_MASK;
      2'd2:    idx = (vaRq >> L2_LO) & L2_MASK;
      default: idx = (vaRq >> L3_LO) & L3_MASK;
    endcase
  end

  assign memAddr = tblBase + (idx << 2);

  always_comb begin
    updated = wordQ;
    updated[REF_BIT] = 1'b1;
    if (wrRq) updated[MOD_BIT] = 1'b1;
  end

  assign wbData      = updated;
  assign stat.kind   = entryKind_e'(wordQ[1:0]);
  assign stat.level  = levelQ;
  assign stat.needWb = (updated != wordQ);
  assign rspEntry    = faultQ ? wordQ : updated;
  assign rspFault    = faultQ;
  assign rspLevel    = levelQ;

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      rspValid,
  input  logic      rspReady,
  output logic      memReqValid,
  input  logic      memReqReady,
  output logic      memReqWrite,
  input  logic      memRspValid,
  input  walkStat_t stat,
  output walkCtl_t  ctl
);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_AWAIT, S_DECODE, S_WRBACK, S_REPLY
  } walkState_e;

  walkState_e st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt         = st;
    ctl         = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    unique case (st)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capture = 1'b1;
          nxt = S_FETCH;
        end
      end
      S_FETCH: begin
        memReqValid = 1'b1;
        if (memReqReady) nxt = S_AWAIT;
      end
      S_AWAIT: begin
        if (memRspValid) begin
          ctl.loadWord = 1'b1;
          nxt = S_DECODE;
        end
      end
      S_DECODE: begin
        if (stat.kind == ET_PTR && stat.level != LAST_LEVEL) begin
          ctl.descend = 1'b1;
          nxt = S_FETCH;
        end else if (stat.kind == ET_LEAF) begin
          nxt = stat.needWb ? S_WRBACK : S_REPLY;
        end else begin
          ctl.markFault = 1'b1;
          nxt = S_REPLY;
        end
      end
      S_WRBACK: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) nxt = S_REPLY;
      end
      S_REPLY: begin
        rspValid = 1'b1;
        if (rspReady) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int CTX_W      = 8,
  parameter int L1_IDX_W   = 8,
  parameter int L2_IDX_W   = 6,
  parameter int L3_IDX_W   = 6,
  parameter int PAGE_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [31:0]      reqVaddr,
  input  logic             reqWrite,
  input  logic [31:0]      ctxBase,
  input  logic [CTX_W-1:0] ctxNum,
  output logic             rspValid,
  input  logic             rspReady,
  output logic             rspFault,
  output logic [1:0]       rspLevel,
  output logic [31:0]      rspEntry,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic             memReqWrite,
  output logic [31:0]      memReqAddr,
  output logic [31:0]      memReqWdata,
  input  logic             memRspValid,
  input  logic [31:0]      memRspRdata
);

  walkCtl_t  ctl;
  walkStat_t stat;

  pgwalk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .rspReady    (rspReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memReqWrite (memReqWrite),
    .memRspValid (memRspValid),
    .stat        (stat),
    .ctl         (ctl)
  );

  pgwalk_dp #(
    .CTX_W      (CTX_W),
    .L1_IDX_W   (L1_IDX_W),
    .L2_IDX_W   (L2_IDX_W),
    .L3_IDX_W   (L3_IDX_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqVaddr (reqVaddr),
    .reqWrite (reqWrite),
    .ctxBase  (ctxBase),
    .ctxNum   (ctxNum),
    .memRdata (memRspRdata),
    .stat     (stat),
    .memAddr  (memReqAddr),
    .wbData   (memReqWdata),
    .rspEntry (rspEntry),
    .rspFault (rspFault),
    .rspLevel (rspLevel)
  );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        rspValid,
  input logic        rspReady,
  input logic        rspFault,
  input logic [1:0]  rspLevel,
  input logic [31:0] rspEntry,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic        memReqWrite,
  input logic [31:0] memReqAddr,
  input logic [31:0] memReqWdata
);

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)
      && $stable(memReqWrite) && $stable(memReqWdata));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspEntry)
      && $stable(rspFault) && $stable(rspLevel));

  a_r8_busy_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  a_r8_busy_mem: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  a_r6_wb_ref: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> memReqWdata[5] && memReqWdata[1:0] == 2'b10);

  a_r3_leaf_ok: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspEntry[1:0] == 2'b10 && rspEntry[5]);

  a_r4_fault_kind: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspEntry[1:0] != 2'b10);

  a_r5_ptr_last: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault && rspEntry[1:0] == 2'b01 |-> rspLevel == 2'd3);

endmodule

bind pgwalk_top pgwalk_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .rspReady    (rspReady),
  .rspFault    (rspFault),
  .rspLevel    (rspLevel),
  .rspEntry    (rspEntry),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqWrite (memReqWrite),
  .memReqAddr  (memReqAddr),
  .memReqWdata (memReqWdata)
);

// File: tb/pgwalk_top_test.sv
`timescale 1ns/1ps
module pgwalk_top_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqWrite;
  logic [31:0] reqVaddr, ctxBase;
  logic [7:0]  ctxNum;
  logic        rspValid, rspReady, rspFault;
  logic [1:0]  rspLevel;
  logic [31:0] rspEntry;
  logic        memReqValid, memReqReady, memReqWrite;
  logic [31:0] memReqAddr, memReqWdata;
  logic        memRspValid;
  logic [31:0] memRspRdata;

  always #2 clk = ~clk;

  pgwalk_top uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .ctxBase(ctxBase), .ctxNum(ctxNum),
    .rspValid(rspValid), .rspReady(rspReady), .rspFault(rspFault),
    .rspLevel(rspLevel), .rspEntry(rspEntry),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspRdata(memRspRdata)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] mem [logic [31:0]];
  int readCount, wbCount;
  logic [31:0] lastWbAddr, lastWbData;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with random request stalls, one-cycle read latency
  initial begin
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspRdata = '0;
    forever begin
      @(posedge clk);
      memRspValid <= 1'b0;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memReqAddr] = memReqWdata;
          wbCount++;
          lastWbAddr = memReqAddr;
          lastWbData = memReqWdata;
        end else begin
          readCount++;
          memRspValid <= 1'b1;
          memRspRdata <= mem.exists(memReqAddr) ? mem[memReqAddr] : 32'h0;
        end
      end
      memReqReady <= ($urandom_range(3) != 0);
    end
  end

  // builds a chain ending in word 'term' at level lvl and runs one lookup
  task automatic walk(input logic [7:0] ctx, input logic [31:0] base, input logic [31:0] va,
                      input bit wr, input int lvl, input logic [31:0] term);
    logic [31:0] tbl [4];
    logic [31:0] addr [4];
    logic [31:0] expEntry, gotEntry;
    bit expFault, expWb, leak, unstable;
    logic gotFault;
    logic [1:0] gotLevel;
    int guard;
    tbl[0] = (base & 32'hFFFF_FFF0) << 4;
    tbl[1] = 32'h0040_0000 | (($urandom & 32'hFFF) << 8);
    tbl[2] = 32'h0080_0000 | (($urandom & 32'hFFF) << 8);
    tbl[3] = 32'h00C0_0000 | (($urandom & 32'hFFF) << 8);
    addr[0] = tbl[0] + 32'(ctx) * 4;
    addr[1] = tbl[1] + 32'(va[31:24]) * 4;
    addr[2] = tbl[2] + 32'(va[23:18]) * 4;
    addr[3] = tbl[3] + 32'(va[17:12]) * 4;
    mem.delete();
    for (int i = 0; i < lvl; i++) mem[addr[i]] = (tbl[i+1] >> 4) | 32'h1;
    mem[addr[lvl]] = term;
    expFault = (term[1:0] != 2'b10);
    expEntry = expFault ? term : (term | 32'h20 | (wr ? 32'h40 : 32'h0));
    expWb    = !expFault && (expEntry != term);

    @(negedge clk);
    readCount = 0; wbCount = 0;
    ctxNum = ctx; ctxBase = base; reqVaddr = va; reqWrite = wr; reqValid = 1'b1;
    guard = 0;
    while (!reqReady && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    reqValid = 1'b0;
    leak = 0; guard = 0;
    while (!rspValid && guard < 1000) begin
      if (reqReady) leak = 1;
      @(negedge clk); guard++;
    end
    gotFault = rspFault; gotLevel = rspLevel; gotEntry = rspEntry;
    unstable = 0;
    repeat ($urandom_range(3)) begin
      @(negedge clk);
      if (reqReady || !rspValid || rspEntry != gotEntry || rspFault != gotFault) unstable = 1;
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;

    chk(rspValid == 1'b0 && leak == 0, "R8 busy window", {31'b0, leak}, 32'h0);
    chk(!unstable, "R9 response hold", {31'b0, unstable}, 32'h0);
    chk(gotFault == expFault, expFault ? "R4/R5 fault flag" : "R3 leaf flag",
        {31'b0, gotFault}, {31'b0, expFault});
    chk(gotLevel == 2'(lvl), "R3 level", {30'b0, gotLevel}, 32'(lvl));
    chk(gotEntry == expEntry, expFault ? "R4 raw word" : "R6 updated entry", gotEntry, expEntry);
    chk(readCount == lvl + 1, "R2 read count", 32'(readCount), 32'(lvl + 1));
    chk(wbCount == (expWb ? 1 : 0), "R7 write count", 32'(wbCount), {31'b0, expWb});
    if (expWb) begin
      chk(lastWbAddr == addr[lvl], "R7 write address", lastWbAddr, addr[lvl]);
      chk(lastWbData == expEntry, "R7 write data", lastWbData, expEntry);
    end
    if (lvl == 3 && term[1:0] == 2'b01)
      chk(gotFault && gotLevel == 2'd3, "R5 pointer at last level", {30'b0, gotLevel}, 32'd3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] t;
    int lv, kind;
    process::self().srandom(32'd2024);
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqVaddr = '0;
    ctxBase = '0; ctxNum = '0; rspReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reqReady && !rspValid && !memReqValid, "R8 reset idle",
        {29'b0, reqReady, rspValid, memReqValid}, 32'h4);
    rstN = 1'b1;

    // leaf at each level, read, referenced clear
    for (int l = 0; l < 4; l++) walk(8'h05, 32'h0010_0000, 32'h1234_5678, 1'b0, l, 32'h0ABC_D08E);
    // R6: referenced already set, read: no write
    walk(8'h11, 32'h0020_0000, 32'hFFFF_F000, 1'b0, 3, 32'h1111_11AE);
    // R6: both set, write: no write
    walk(8'h11, 32'h0020_0000, 32'h0000_0000, 1'b1, 2, 32'h2222_22EE);
    // R7: referenced set, modified clear, write
    walk(8'h22, 32'h0030_0000, 32'h8040_3000, 1'b1, 1, 32'h3333_33A6);
    // R4: invalid and reserved at several levels
    walk(8'h01, 32'h0040_0000, 32'h0102_0304, 1'b0, 0, 32'h0000_0000);
    walk(8'h02, 32'h0040_0000, 32'h0102_0304, 1'b1, 2, 32'hDEAD_BEEF);
    walk(8'h03, 32'h0040_0000, 32'hFFFF_FFFF, 1'b0, 3, 32'h5555_5550);
    // R5: pointer at level 3
    walk(8'h04, 32'h0050_0000, 32'h7654_3210, 1'b0, 3, 32'h0001_2341);
    // R1: top context (carry into bit 8) and stray base bits
    walk(8'hFF, 32'hF0F0_0F0F, 32'hA5A5_A5A5, 1'b1, 3, 32'h9999_9902);
    walk(8'hC0, 32'h3FFF_FFF7, 32'h5A5A_5A5A, 1'b0, 1, 32'h4444_4402);

    for (int n = 0; n < 200; n++) begin
      lv = $urandom_range(3);
      kind = $urandom_range(9);
      t = $urandom;
      if (kind < 6) t[1:0] = 2'b10;
      else if (kind == 6) t[1:0] = 2'b00;
      else if (kind == 7) t[1:0] = 2'b11;
      else t[1:0] = (lv == 3) ? 2'b01 : 2'b10;
      walk(8'($urandom), ($urandom & 32'h00FF_FFF0) | 32'h00F0_0000 | 32'($urandom_range(15)),
           $urandom, 1'($urandom), lv, t);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule